// File: doc/BRIEF.md
# Indexed Interrupt Distributor with Per-CPU Acknowledge

This block gathers a set of level-sensitive interrupt sources and hands each one to one or more CPUs. Software controls it through a 32-bit register port that has two windows: a global window shared by all CPUs and a per-CPU window whose target is the CPU identifier that travels with the bus access. Enable and mask state is never written as a bit field. Software writes the number of the source to a "set" or "clear" register. This removes the read-modify-write races that occur between CPUs.

Every source has its own routing word that selects the CPUs it may reach. A source qualifies for a CPU when four conditions hold together: its input is high, it is globally enabled, its routing bit for that CPU is set, and that CPU has not masked it. Each CPU reads an acknowledge register that returns the lowest qualifying source number. A reserved number means nothing is pending. Each CPU also has a registered interrupt line that follows the same condition. Sources 0 and 1 are summary lines from doorbell logic outside this block. The block treats them like any other source, so they win over every other source when several qualify.

Top module: `irq_distrib`

## Requirements
- R1: A global read of offset 0x000 returns the number of implemented sources (parameter NUM_SRC, default 32) in bits [11:2], with all other bits zero.
- R2: A global write to offset 0x030 enables the source whose number is in wdata[9:0]. A global write to 0x034 disables that source. A number of NUM_SRC or more changes no source.
- R3: Source n has a routing word at global offset 0x100 + 4*n. Bit c of the word (c < NUM_CPU, default 4) routes the source to CPU c, and several bits may be set. The word reads back with all bits at and above NUM_CPU equal to zero.
- R4: A per-CPU write to offset 0x048 masks the source numbered in wdata[9:0] for the accessing CPU only. A write to 0x04C unmasks it for that CPU only.
- R5: A per-CPU read of offset 0x044 returns, in bits [9:0], the lowest-numbered source that is high, enabled, routed to and unmasked for the accessing CPU. It returns 1023 when no source qualifies. Bits [31:10] read zero.
- R6: Sources are level-sensitive and the input is sampled through one register stage. A source stops qualifying once its input falls. Reading the acknowledge register has no side effect, so repeated reads return the same number.
- R7: cpu_irq[c] is high exactly when an acknowledge read by CPU c would return a valid source number. It is registered and follows a change of register state one clock later, and a change of a source input two clocks later.
- R8: A synchronous reset disables all sources, masks every source for every CPU, clears every routing word, drives cpu_irq low and drops bus_rvalid.
- R9: Read data appears on bus_rdata, with bus_rvalid high, in the cycle after the cycle in which bus_rd is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_local | input | 1 | 1 selects the per-CPU window, 0 the global window |
| bus_cpu | input | CPU_W | Identifier of the accessing CPU |
| bus_addr | input | ADDR_W | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| src_level | input | NUM_SRC | Level-sensitive source inputs; bits 0 and 1 are the doorbell summaries |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench has several sources qualify at once and then removes them one at a time, so it checks that the lowest number wins. A reversed priority encoder would return 9 where 0 is expected. It writes an index that aliases a real source when truncated (37 onto 5), which catches a decoder that drops the upper index bits and so enables the wrong source. It masks a source on one CPU and unmasks it on another to show the mask is private to each CPU. A design with one shared mask would let the second write undo the first. It reads the acknowledge register twice in a row, and lowers source inputs with everything still enabled. An acknowledge that clears state, or a pending bit that latches, would report the wrong number after those steps.

// File: rtl/irq_distrib_pkg.sv
package irq_distrib_pkg;
  localparam int IDX_W = 10;
  localparam logic [IDX_W-1:0] NO_SRC = 10'd1023;

  localparam logic [11:0] OFF_CTRL      = 12'h000;
  localparam logic [11:0] OFF_EN_SET    = 12'h030;
  localparam logic [11:0] OFF_EN_CLR    = 12'h034;
  localparam logic [11:0] OFF_ROUTE     = 12'h100;
  localparam logic [11:0] OFF_ACK       = 12'h044;
  localparam logic [11:0] OFF_MASK_SET  = 12'h048;
  localparam logic [11:0] OFF_MASK_CLR  = 12'h04C;

  typedef logic [IDX_W-1:0] src_idx_t;
endpackage

// File: rtl/irq_index_bank.sv
module irq_index_bank
  import irq_distrib_pkg::*;
#(
  parameter int N       = 32,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  src_idx_t     idx,
  output logic [N-1:0] bits_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= {N{RST_VAL}};
    end else begin
      for (int i = 0; i < N; i++) begin
        if (idx == IDX_W'(i)) begin
          if (set_stb)      bits_q[i] <= 1'b1;
          else if (clr_stb) bits_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
  import irq_distrib_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] req,
  output logic         found,
  output src_idx_t     idx
);
  always_comb begin
    found = 1'b0;
    idx   = NO_SRC;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_distrib.sv
module irq_distrib
  import irq_distrib_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_local,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_SRC-1:0] src_level,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(OFF_ROUTE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(OFF_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(OFF_MASK_CLR);

  // Input sampling stage
  logic [NUM_SRC-1:0] src_q;
  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_level;
  end

  // Decode
  src_idx_t wr_idx;
  logic     g_wr, l_wr;
  assign wr_idx = bus_wdata[IDX_W-1:0];
  assign g_wr   = bus_wr && !bus_local;
  assign l_wr   = bus_wr &&  bus_local;

  // Global enable bank
  logic [NUM_SRC-1:0] en_q;
  irq_index_bank #(.N(NUM_SRC), .RST_VAL(1'b0)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .set_stb (g_wr && bus_addr == A_EN_SET),
    .clr_stb (g_wr && bus_addr == A_EN_CLR),
    .idx     (wr_idx),
    .bits_q  (en_q)
  );

  // Routing words
  logic [ADDR_W-1:0]  route_off;
  logic               route_hit;
  logic [NUM_CPU-1:0] route_q [NUM_SRC];
  assign route_off = bus_addr - A_ROUTE;
  assign route_hit = (bus_addr >= A_ROUTE) && (bus_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NUM_SRC; n++) route_q[n] <= '0;
    end else if (g_wr && route_hit) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (route_off[ADDR_W-1:2] == (ADDR_W-2)'(n))
          route_q[n] <= bus_wdata[NUM_CPU-1:0];
      end
    end
  end

  // Per-CPU mask banks, qualification and selection
  src_idx_t           ack_idx [NUM_CPU];
  logic [NUM_CPU-1:0] ack_found;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] qual;
    logic               this_cpu;

    assign this_cpu = (bus_cpu == CPU_W'(c));

    irq_index_bank #(.N(NUM_SRC), .RST_VAL(1'b1)) u_mask (
      .clk     (clk),
      .rst     (rst),
      .set_stb (l_wr && this_cpu && bus_addr == A_MSET),
      .clr_stb (l_wr && this_cpu && bus_addr == A_MCLR),
      .idx     (wr_idx),
      .bits_q  (mask_q)
    );

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_q
      assign qual[n] = src_q[n] && en_q[n] && route_q[n][c] && !mask_q[n];
    end

    irq_lowest_pick #(.N(NUM_SRC)) u_pick (
      .req   (qual),
      .found (ack_found[c]),
      .idx   (ack_idx[c])
    );
  end

  // Interrupt outputs
  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= '0;
    else     cpu_irq <= ack_found;
  end

  // Read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_local) begin
      if (bus_addr == A_ACK) rd_mux[IDX_W-1:0] = ack_idx[bus_cpu];
    end else if (bus_addr == A_CTRL) begin
      rd_mux[11:2] = 10'(NUM_SRC);
    end else if (route_hit) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (route_off[ADDR_W-1:2] == (ADDR_W-2)'(n))
          rd_mux[NUM_CPU-1:0] = route_q[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_distrib_chk.sv
module irq_distrib_chk
  import irq_distrib_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_rd,
  input logic               bus_local,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CPU-1:0] cpu_irq
);
  logic ack_rd, ctrl_rd, route_rd;
  assign ack_rd   = bus_rd && bus_local && bus_addr == ADDR_W'(OFF_ACK);
  assign ctrl_rd  = bus_rd && !bus_local && bus_addr == ADDR_W'(OFF_CTRL);
  assign route_rd = bus_rd && !bus_local && bus_addr >= ADDR_W'(OFF_ROUTE);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (cpu_irq == '0 && !bus_rvalid));

  // R9
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R9
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  // R1
  ctrl_count_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> bus_rdata == (32'(NUM_SRC) << 2));

  // R3
  route_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    route_rd |=> bus_rdata[31:NUM_CPU] == '0);

  // R5
  ack_range_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> (bus_rdata[31:IDX_W] == '0 &&
                (bus_rdata[IDX_W-1:0] == NO_SRC ||
                 32'(bus_rdata[IDX_W-1:0]) < NUM_SRC)));

  // R7
  ack_matches_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> ((bus_rdata[IDX_W-1:0] != NO_SRC) == cpu_irq[$past(bus_cpu)]));
endmodule

bind irq_distrib irq_distrib_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_local  (bus_local),
  .bus_cpu    (bus_cpu),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .cpu_irq    (cpu_irq)
);

// File: tb/irq_distrib_tb.sv
module irq_distrib_tb;
  localparam int NS = 32;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_local = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NS-1:0] src_level = '0;
  logic [NC-1:0] cpu_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_distrib #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(12)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_local(bus_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_level(src_level), .cpu_irq(cpu_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit loc, int cpu, int addr, int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_local = loc; bus_cpu = 2'(cpu);
    bus_addr = 12'(addr); bus_wdata = 32'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit loc, int cpu, int addr, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_local = loc; bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R8 irq after reset", 32'(cpu_irq), 32'h0);
    rd(1'b0, 0, 'h000, d);
    check("R1 control count", d, 32'd128);
    rd(1'b1, 0, 'h044, d);
    check("R8 ack none after reset", d, 32'd1023);
    rd(1'b0, 0, 'h114, d);
    check("R8 route zero after reset", d, 32'h0);
  endtask

  task automatic t_basic_route();
    logic [31:0] d;
    src_level[5] = 1'b1;
    wr(1'b0, 0, 'h114, 'h2);
    wr(1'b0, 0, 'h030, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R4 still masked after reset", d, 32'd1023);
    wr(1'b1, 1, 'h04C, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R5 ack cpu1 src5", d, 32'd5);
    check("R7 irq cpu1 only", 32'(cpu_irq), 32'h2);
    wr(1'b1, 0, 'h04C, 5);
    settle();
    rd(1'b1, 0, 'h044, d);
    check("R3 unrouted cpu0 sees none", d, 32'd1023);
  endtask

  task automatic t_mask_private();
    logic [31:0] d;
    wr(1'b1, 1, 'h048, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R4 masked cpu1", d, 32'd1023);
    check("R7 irq low when masked", 32'(cpu_irq), 32'h0);
    wr(1'b1, 2, 'h04C, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R4 other cpu unmask no effect", d, 32'd1023);
    wr(1'b1, 1, 'h04C, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R4 unmask restores", d, 32'd5);
  endtask

  task automatic t_enable_index();
    logic [31:0] d;
    wr(1'b0, 0, 'h034, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R2 disable", d, 32'd1023);
    wr(1'b0, 0, 'h030, 37);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R2 out-of-range index ignored", d, 32'd1023);
    check("R7 irq low after bad index", 32'(cpu_irq), 32'h0);
    wr(1'b0, 0, 'h030, 5);
    settle();
    rd(1'b1, 1, 'h044, d);
    check("R2 re-enable", d, 32'd5);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    src_level[0] = 1'b1; src_level[1] = 1'b1; src_level[9] = 1'b1;
    wr(1'b0, 0, 'h100, 'h4);
    wr(1'b0, 0, 'h104, 'h4);
    wr(1'b0, 0, 'h124, 'hF);
    for (int s = 0; s < 3; s++) begin
      int id = (s == 2) ? 9 : s;
      wr(1'b0, 0, 'h030, id);
      wr(1'b1, 2, 'h04C, id);
    end
    wr(1'b1, 3, 'h04C, 9);
    settle();
    rd(1'b1, 2, 'h044, d);
    check("R5 lowest wins src0", d, 32'd0);
    rd(1'b1, 2, 'h044, d);
    check("R6 ack read no side effect", d, 32'd0);
    rd(1'b1, 3, 'h044, d);
    check("R3 multi-hot route cpu3", d, 32'd9);
    check("R7 irq cpus 1,2,3", 32'(cpu_irq), 32'hE);
    src_level[0] = 1'b0;
    settle();
    rd(1'b1, 2, 'h044, d);
    check("R6 level drop src0 -> src1", d, 32'd1);
    src_level[1] = 1'b0;
    settle();
    rd(1'b1, 2, 'h044, d);
    check("R6 level drop src1 -> src9", d, 32'd9);
    src_level[9] = 1'b0; src_level[5] = 1'b0;
    settle();
    rd(1'b1, 2, 'h044, d);
    check("R6 all dropped", d, 32'd1023);
    check("R7 irq all low", 32'(cpu_irq), 32'h0);
  endtask

  task automatic t_route_bits();
    logic [31:0] d;
    wr(1'b0, 0, 'h11C, 32'hFFFF_FFF3);
    rd(1'b0, 0, 'h11C, d);
    check("R3 route readback width", d, 32'h3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_route();
    t_mask_private();
    t_enable_index();
    t_priority();
    t_route_bits();
    finish_run();
  end
endmodule